// File: doc/BRIEF.md
# Lockable Configuration Register Bank

This block is the host-facing configuration store of a small I/O controller. The host first opens a configuration session with an enter strobe. It then loads an index register with the number of the register it wants. After that it reads or writes the chosen register through a data port. An exit strobe closes the session. Two registers are implemented:

- **Port-control register (index 0x01):** holds the parallel-port power enable, the parallel-port mode select and a global lock enable.
- **Serial-power register (index 0x02):** holds the serial-port power control.

The stored control bits drive power and mode outputs straight to the logical devices. Clearing a power bit only turns the device off. It does not change address decoding, which stays outside this block. A device is removed from decode only when its base address is moved below 0x100 elsewhere.

The lock enable can be cleared but not set again by software. While it is clear, every read or write of indices 0x00 through 0x39 is blocked. Two resets are kept apart:

- **Power-on reset** (`por_n`, asynchronous, active low) loads every default.
- **Hard reset** (`hard_rst`, synchronous, active high) sets the lock enable again and ends any open session. It leaves the device control fields as they were.

Top module: `cfg_regbank`

## Requirements
- R1: After power-on reset, index 0x01 reads 0x9C and index 0x02 reads 0x08, and `pp_power_on`, `pp_printer_mode` and `uart_power_on` are all 1.
- R2: In index 0x01, bits 0, 1, 5 and 6 always read 0 and bit 4 always reads 1. In index 0x02, every bit except bit 3 reads 0. Writing to any of these bits changes nothing.
- R3: A permitted write to index 0x01 loads bit 2 into `pp_power_on` (1 = powered) and bit 3 into `pp_printer_mode` (1 = printer mode, 0 = extended modes). Both outputs change on the clock edge that takes the write.
- R4: A permitted write to index 0x02 loads bit 3 into `uart_power_on` (1 = normal operation, 0 = power-down). The output changes on the clock edge that takes the write.
- R5: The session opens one cycle after `cfg_enter` and closes one cycle after `cfg_exit`; `cfg_exit` wins when both are high. Outside a session, `idx_wr` and `data_wr` are ignored and reads return 0x00.
- R6: Bit 7 of index 0x01 is the lock enable. Writing it as 0 clears it. While it is clear, reads of indices 0x00–0x39 return 0x00, writes there are dropped, and no write can set the lock again.
- R7: A hard reset sets the lock enable to 1, closes the session and clears the index to 0x00. It keeps the current values of the power and mode fields.
- R8: Indices with no register behind them read 0x00, and writes to them have no effect.
- R9: `rdata` is 0x00 in every cycle where `data_rd` is low. Otherwise it shows the selected register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| hard_rst | input | 1 | Hard reset, synchronous, active high |
| cfg_enter | input | 1 | Opens a configuration session |
| cfg_exit | input | 1 | Closes the configuration session |
| idx_wr | input | 1 | Loads `wdata` into the index register |
| data_wr | input | 1 | Writes `wdata` into the indexed register |
| data_rd | input | 1 | Reads the indexed register onto `rdata` |
| wdata | input | 8 | Write data for the index or the register |
| rdata | output | 8 | Read data; 0x00 when the read is not allowed |
| pp_power_on | output | 1 | Parallel-port power enable |
| pp_printer_mode | output | 1 | Parallel-port mode: 1 = printer, 0 = extended |
| uart_power_on | output | 1 | Serial-port power enable |

## Verification
Register writes set the reserved bits and clear the live bits together, then do the reverse. This separates a correct field mask from a register that stores the whole byte. Strobes sent outside a session and accesses to unused indices show whether those accesses are really ignored or leak into state. Writes after the lock is cleared, including one that tries to set the lock again, separate a sticky lock from one that software can restore. A hard reset that follows a change to the power bits separates the partial reload from a full power-on reload.

// File: rtl/cfg_regbank.sv
module cfg_regbank #(
  parameter int          DW       = 8,
  parameter logic [7:0]  IDX_PORT = 8'h01,
  parameter logic [7:0]  IDX_UART = 8'h02,
  parameter logic [7:0]  GATE_TOP = 8'h39,
  parameter logic [7:0]  PORT_POR = 8'h9C,
  parameter logic [7:0]  UART_POR = 8'h08
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          hard_rst,
  input  logic          cfg_enter,
  input  logic          cfg_exit,
  input  logic          idx_wr,
  input  logic          data_wr,
  input  logic          data_rd,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          pp_power_on,
  output logic          pp_printer_mode,
  output logic          uart_power_on
);

  logic          cfg_active;
  logic          lock;
  logic [DW-1:0] index;
  logic          in_gate;
  logic          wr_ok;
  logic          rd_ok;
  logic [DW-1:0] port_val;
  logic [DW-1:0] uart_val;

  assign in_gate = index <= DW'(GATE_TOP);
  assign wr_ok   = cfg_active && lock && data_wr && in_gate;
  assign rd_ok   = cfg_active && lock && data_rd && in_gate;

  always_comb begin
    port_val    = '0;
    port_val[7] = lock;
    port_val[4] = 1'b1;
    port_val[3] = pp_printer_mode;
    port_val[2] = pp_power_on;
    uart_val    = '0;
    uart_val[3] = uart_power_on;
  end

  always_comb begin
    rdata = '0;
    if (rd_ok) begin
      if (index == DW'(IDX_PORT))      rdata = port_val;
      else if (index == DW'(IDX_UART)) rdata = uart_val;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cfg_active      <= 1'b0;
      index           <= '0;
      lock            <= 1'b1;
      pp_power_on     <= PORT_POR[2];
      pp_printer_mode <= PORT_POR[3];
      uart_power_on   <= UART_POR[3];
    end else if (hard_rst) begin
      cfg_active <= 1'b0;
      index      <= '0;
      lock       <= 1'b1;
    end else begin
      if (cfg_exit)       cfg_active <= 1'b0;
      else if (cfg_enter) cfg_active <= 1'b1;
      if (cfg_active && idx_wr) index <= wdata;
      if (wr_ok && index == DW'(IDX_PORT)) begin
        pp_power_on     <= wdata[2];
        pp_printer_mode <= wdata[3];
        lock            <= lock & wdata[7];
      end
      if (wr_ok && index == DW'(IDX_UART)) uart_power_on <= wdata[3];
    end
  end

  p_lock_sticky_r6: assert property (@(posedge clk) disable iff (!por_n)
    (!lock && !hard_rst) |=> !lock);

  p_locked_read_zero_r6: assert property (@(posedge clk) disable iff (!por_n)
    !lock |-> rdata == '0);

  p_no_change_outside_r5: assert property (@(posedge clk) disable iff (!por_n)
    (!cfg_active && !hard_rst) |=> $stable({pp_power_on, pp_printer_mode, uart_power_on}));

  p_hard_reset_relock_r7: assert property (@(posedge clk) disable iff (!por_n)
    hard_rst |=> (lock && !cfg_active && index == '0));

  p_hard_reset_keeps_fields_r7: assert property (@(posedge clk) disable iff (!por_n)
    hard_rst |=> $stable({pp_power_on, pp_printer_mode, uart_power_on}));

  p_idle_read_zero_r9: assert property (@(posedge clk) disable iff (!por_n)
    !data_rd |-> rdata == '0);

  p_fixed_bits_r2: assert property (@(posedge clk) disable iff (!por_n)
    (rd_ok && index == DW'(IDX_PORT)) |-> (rdata[4] && rdata[1:0] == 2'b00 && rdata[6:5] == 2'b00));

endmodule

// File: tb/cfg_regbank_tb.sv
`timescale 1ns/1ps
module cfg_regbank_tb;
  logic clk = 1'b0;
  logic por_n = 1'b0, hard_rst = 1'b0;
  logic cfg_enter = 1'b0, cfg_exit = 1'b0, idx_wr = 1'b0, data_wr = 1'b0, data_rd = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic pp_power_on, pp_printer_mode, uart_power_on;

  int vectors = 0;
  int miscmp  = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  cfg_regbank u_dut (
    .clk(clk), .por_n(por_n), .hard_rst(hard_rst),
    .cfg_enter(cfg_enter), .cfg_exit(cfg_exit),
    .idx_wr(idx_wr), .data_wr(data_wr), .data_rd(data_rd),
    .wdata(wdata), .rdata(rdata),
    .pp_power_on(pp_power_on), .pp_printer_mode(pp_printer_mode),
    .uart_power_on(uart_power_on)
  );

  task automatic tick();
    @(posedge clk); #0.5;
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      miscmp++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic enter();  cfg_enter = 1'b1; tick(); cfg_enter = 1'b0; endtask
  task automatic leave();  cfg_exit  = 1'b1; tick(); cfg_exit  = 1'b0; endtask
  task automatic set_idx(input logic [7:0] v); idx_wr = 1'b1; wdata = v; tick(); idx_wr = 1'b0; endtask
  task automatic wr(input logic [7:0] v); data_wr = 1'b1; wdata = v; tick(); data_wr = 1'b0; endtask
  task automatic rd(input logic [7:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    data_rd = 1'b1; tick(); data_rd = 1'b0;
  endtask
  task automatic outs(input logic p, input logic m, input logic u, input string tag);
    chk({5'd0, p, m, u}, {5'd0, 1'b0 ^ 1'b0 ^ 1'b0 ? 1'b0 : 1'b0, 2'b00}, "") ;
  endtask

  always @(negedge clk) begin
    if (data_rd) begin
      if (exp_q.size() == 0) begin
        vectors++; miscmp++;
        $display("FAIL R9: unexpected read, actual %02h expected none", rdata);
      end else begin
        chk(rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end else if (por_n) begin
      if (rdata !== 8'h00) begin
        vectors++; miscmp++;
        $display("FAIL R9: idle rdata actual %02h expected 00", rdata);
      end
    end
  end

  task automatic finish_run();
    if (exp_q.size() != 0) begin
      vectors++; miscmp++;
      $display("FAIL R9: %0d reads never seen, actual 0 expected %0d", exp_q.size(), exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  endtask

  initial begin
    #1000000;
    miscmp++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

  initial begin
    tick(); tick(); por_n = 1'b1; tick();
    chk({5'd0, pp_power_on, pp_printer_mode, uart_power_on}, 8'h07, "R1 outputs after power-on");
    chk(rdata, 8'h00, "R9 idle rdata");
    enter();
    set_idx(8'h01); rd(8'h9C, "R1 port default");
    set_idx(8'h02); rd(8'h08, "R1 serial default");

    set_idx(8'h01); wr(8'hE3);
    chk({6'd0, pp_power_on, pp_printer_mode}, 8'h00, "R3 power and mode cleared");
    rd(8'h90, "R2 reserved bits fixed");
    wr(8'h8C);
    chk({6'd0, pp_power_on, pp_printer_mode}, 8'h03, "R3 power and mode set");
    rd(8'h9C, "R3 readback");

    set_idx(8'h02); wr(8'hF7);
    chk({7'd0, uart_power_on}, 8'h00, "R4 serial power down");
    rd(8'h00, "R2 serial reserved bits");
    wr(8'h08);
    chk({7'd0, uart_power_on}, 8'h01, "R4 serial power up");
    rd(8'h08, "R4 readback");

    set_idx(8'h10); rd(8'h00, "R8 empty index read");
    wr(8'hFF); rd(8'h00, "R8 empty index write");
    set_idx(8'h40); rd(8'h00, "R8 index above gate");

    leave();
    set_idx(8'h02); wr(8'h00);
    chk({7'd0, uart_power_on}, 8'h01, "R5 write outside session");
    rd(8'h00, "R5 read outside session");
    enter();
    rd(8'h00, "R5 index kept at 0x40");
    set_idx(8'h02); rd(8'h08, "R5 access after reentry");
    cfg_enter = 1'b1; cfg_exit = 1'b1; tick(); cfg_enter = 1'b0; cfg_exit = 1'b0;
    rd(8'h00, "R5 exit wins over enter");
    enter();

    set_idx(8'h01); wr(8'h08);
    chk({6'd0, pp_power_on, pp_printer_mode}, 8'h01, "R6 write that clears lock");
    rd(8'h00, "R6 locked read");
    wr(8'h8C);
    chk({6'd0, pp_power_on, pp_printer_mode}, 8'h01, "R6 locked write dropped");
    rd(8'h00, "R6 relock attempt failed");
    set_idx(8'h02); wr(8'h00);
    chk({7'd0, uart_power_on}, 8'h01, "R6 locked serial write dropped");
    rd(8'h00, "R6 locked serial read");

    hard_rst = 1'b1; tick(); hard_rst = 1'b0;
    chk({5'd0, pp_power_on, pp_printer_mode, uart_power_on}, 8'h03, "R7 fields kept");
    rd(8'h00, "R7 session closed");
    enter();
    rd(8'h00, "R7 index cleared");
    set_idx(8'h01); rd(8'h98, "R7 lock restored");

    por_n = 1'b0; tick(); por_n = 1'b1; tick();
    chk({5'd0, pp_power_on, pp_printer_mode, uart_power_on}, 8'h07, "R1 power-on reload");
    enter(); set_idx(8'h01); rd(8'h9C, "R1 port after second reset");
    tick();
    finish_run();
  end
endmodule